// File: doc/BRIEF.md
# Ratio-Table Clock-Enable Divider Bank

The block derives eleven divided clock-enable streams from one fast source tick. Each output runs a down-counter whose length is chosen by a 4-bit ratio code. The code indexes a fixed table of divisors, and that table is not limited to powers of two. The outputs are one-cycle enable pulses, not gated clocks, so every consumer stays on the same clock and samples its own enable.

Software programs the ratio codes through a small single-cycle register port. Two 32-bit control words hold the code fields, a third word holds sticky rejection flags, and a fourth holds the per-output run enables. Writes only change shadow copies. Setting the kick bit requests an update. The update then waits until every running counter is at its terminal count, and at that point all outputs take their new ratio and run state in the same cycle. No output ever produces a shortened or stretched period. A shadow code that is reserved, outside the table, or forbidden for its output is refused: that output keeps its old divisor and its error flag is set.

Top module: `div_bank`

## Requirements
- R1: Ratio codes map to divisors as follows: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. Code 9 and codes 12 to 15 are not valid divisors.
- R2: A running output emits a one-cycle high pulse on `pulse_o[k]` once every D cycles in which `tick_i` is high, where D is its active divisor. When `tick_i` is high every other cycle, the pulse period in clock cycles doubles.
- R3: Register writes change only the shadow codes. Reads return the shadow values, with unused bits reading 0. The active divisor is unchanged until a kick is serviced.
- R4: Writing address 1 with bit 31 set makes a kick pending, and bit 31 of address 1 reads 1 while the kick is pending. The kick is serviced on the first cycle in which `tick_i` is high and every running counter is at zero. At that point all outputs load their new code and run state together, and bit 31 clears.
- R5: When a kick is serviced, an output whose shadow code is invalid keeps its previous divisor and sets bit k of the status word at address 2. Code 10 is also invalid for outputs 1 and 6. Status bits are sticky, and writing 1 to a status bit clears it.
- R6: The code fields are these. Address 0 holds outputs 0, 1, 2, 4 and 5 at bit offsets 20, 16, 8, 4 and 0, and output 3 shares the field at offset 8 with output 2. Address 1 holds outputs 6, 7, 8, 9 and 10 at offsets 24, 20, 16, 12 and 4.
- R7: After reset all codes are 0 (divide by 2). Outputs 0 to 3 run, and outputs 4 to 10 are stopped and emit no pulses. Address 3 bits 10:0 are the shadow run enables. They read 0x00F after reset and take effect at a kick.
- R8: While `tick_i` is low, the counters hold their value, a pending kick is not serviced, and no pulses appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Source tick that advances all dividers |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| pulse_o | output | 11 | Divided enable pulses, one per output |

## Verification
Register reads are combinational, so the bench samples read data one time step after it sets the address, during the low phase of the clock. A pulse is registered: it appears on the edge that follows the tick cycle in which the counter sits at zero. Periods are therefore measured from one sampled pulse to the next, at falling edges. A kick completes within one common period of the running divisors, at most 144 ticks. The bench polls the kick bit with a bounded wait and only then measures the new period, so it never samples during the switch.

// File: rtl/div_bank_pkg.sv
package div_bank_pkg;
  localparam int NUM_OUT  = 11;
  localparam int CODE_W   = 4;
  localparam int CNT_W    = 6;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int KICK_BIT = 31;
  localparam int DIV_RST  = 2;

  localparam logic [ADDR_W-1:0] ADDR_A   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_B   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ST  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RUN = 2'd3;

  // field offset per output; output 3 shares output 2's field
  localparam int unsigned FLD_LSB [NUM_OUT] = '{20, 16, 8, 8, 4, 0, 24, 20, 16, 12, 4};
  localparam logic [NUM_OUT-1:0] IN_B  = 11'b111_1100_0000;
  localparam logic [NUM_OUT-1:0] NO_36 = 11'b000_0100_0010;

  function automatic logic [REG_W-1:0] field_mask(input logic sel_b);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_OUT; i++)
      if (IN_B[i] == sel_b) m[FLD_LSB[i] +: CODE_W] = '1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] MASK_A = field_mask(1'b0);
  localparam logic [REG_W-1:0] MASK_B = field_mask(1'b1);
endpackage

// File: rtl/div_lut.sv
module div_lut
  import div_bank_pkg::*;
#(
  parameter bit BLOCK_36 = 1'b0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  div_o,
  output logic              ok_o
);
  always_comb begin
    unique case (code_i)
      4'd0:    div_o = CNT_W'(2);
      4'd1:    div_o = CNT_W'(3);
      4'd2:    div_o = CNT_W'(4);
      4'd3:    div_o = CNT_W'(6);
      4'd4:    div_o = CNT_W'(8);
      4'd5:    div_o = CNT_W'(12);
      4'd6:    div_o = CNT_W'(16);
      4'd7:    div_o = CNT_W'(18);
      4'd8:    div_o = CNT_W'(24);
      4'd10:   div_o = CNT_W'(36);
      4'd11:   div_o = CNT_W'(48);
      default: div_o = '0;
    endcase
    ok_o = (div_o != '0) && !(BLOCK_36 && code_i == 4'd10);
  end
endmodule

// File: rtl/div_counter.sv
module div_counter
  import div_bank_pkg::*;
#(
  parameter bit BLOCK_36 = 1'b0,
  parameter bit RUN_RST  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              apply_i,
  input  logic [CODE_W-1:0] new_code_i,
  input  logic              new_run_i,
  output logic              idle_o,
  output logic              reject_o,
  output logic              pulse_o
);
  logic [CNT_W-1:0] div_q, cnt_q, new_div, eff_div;
  logic             run_q, new_ok, pulse_q;

  div_lut #(.BLOCK_36(BLOCK_36)) u_lut (
    .code_i (new_code_i),
    .div_o  (new_div),
    .ok_o   (new_ok)
  );

  assign eff_div  = (apply_i && new_ok) ? new_div : div_q;
  assign idle_o   = (cnt_q == '0);
  assign reject_o = apply_i && !new_ok;
  assign pulse_o  = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= CNT_W'(DIV_RST);
      cnt_q   <= '0;
      run_q   <= RUN_RST;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick_i && run_q && (cnt_q == '0);
      if (apply_i) begin
        run_q <= new_run_i;
        div_q <= eff_div;
        // all counters reload together so they stay phase aligned
        cnt_q <= new_run_i ? eff_div - 1'b1 : '0;
      end else if (tick_i) begin
        if (!run_q)             cnt_q <= '0;
        else if (cnt_q == '0)   cnt_q <= div_q - 1'b1;
        else                    cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q);
  a_r2_pulse_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(run_q));
  a_r8_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q) && !pulse_q);
  a_r4_apply_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |-> (cnt_q == '0) && tick_i);
  a_r5_reject_keeps_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> $stable(div_q));
endmodule

// File: rtl/div_regs.sv
module div_regs
  import div_bank_pkg::*;
#(
  parameter logic [NUM_OUT-1:0] RUN_RST = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [REG_W-1:0]               rdata_o,
  input  logic                           apply_i,
  input  logic [NUM_OUT-1:0]             reject_i,
  output logic [NUM_OUT-1:0][CODE_W-1:0] codes_o,
  output logic [NUM_OUT-1:0]             run_o,
  output logic                           pend_o
);
  logic [REG_W-1:0]   sh_a, sh_b;
  logic [NUM_OUT-1:0] sh_run, err_q, err_clr;
  logic               pend_q, kick_wr;

  assign kick_wr = we_i && (addr_i == ADDR_B) && wdata_i[KICK_BIT];
  assign err_clr = (we_i && addr_i == ADDR_ST) ? wdata_i[NUM_OUT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a   <= '0;
      sh_b   <= '0;
      sh_run <= RUN_RST;
      err_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          ADDR_A:   sh_a   <= wdata_i & MASK_A;
          ADDR_B:   sh_b   <= wdata_i & MASK_B;
          ADDR_RUN: sh_run <= wdata_i[NUM_OUT-1:0];
          default:  ;
        endcase
      end
      err_q <= (err_q & ~err_clr) | reject_i;
      if (kick_wr)      pend_q <= 1'b1;
      else if (apply_i) pend_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_fld
    if (IN_B[k]) begin : g_b
      assign codes_o[k] = sh_b[FLD_LSB[k] +: CODE_W];
    end else begin : g_a
      assign codes_o[k] = sh_a[FLD_LSB[k] +: CODE_W];
    end
  end

  assign run_o  = sh_run;
  assign pend_o = pend_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_A:   rdata_o = sh_a;
      ADDR_B:   begin rdata_o = sh_b; rdata_o[KICK_BIT] = pend_q; end
      ADDR_ST:  rdata_o[NUM_OUT-1:0] = err_q;
      ADDR_RUN: rdata_o[NUM_OUT-1:0] = sh_run;
      default:  ;
    endcase
  end

  a_r4_kick_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_wr |=> pend_q);
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_ST) |=> ((err_q & $past(err_q)) == $past(err_q)));
  a_r3_shadow_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sh_a) && $stable(sh_b) && $stable(sh_run));
endmodule

// File: rtl/div_bank.sv
module div_bank
  import div_bank_pkg::*;
#(
  parameter logic [NUM_OUT-1:0] RUN_RST = 11'h00F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [NUM_OUT-1:0] pulse_o
);
  logic [NUM_OUT-1:0][CODE_W-1:0] codes;
  logic [NUM_OUT-1:0]             run_sh, idle, reject;
  logic                           pend, apply;

  assign apply = pend && tick_i && (&idle);

  div_regs #(.RUN_RST(RUN_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .apply_i  (apply),
    .reject_i (reject),
    .codes_o  (codes),
    .run_o    (run_sh),
    .pend_o   (pend)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_div
    div_counter #(.BLOCK_36(NO_36[k]), .RUN_RST(RUN_RST[k])) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .apply_i    (apply),
      .new_code_i (codes[k]),
      .new_run_i  (run_sh[k]),
      .idle_o     (idle[k]),
      .reject_o   (reject[k]),
      .pulse_o    (pulse_o[k])
    );
  end

  a_r4_pend_clears_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend) |-> $past(tick_i && (&idle)));
  a_r8_no_kick_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !tick_i) |=> pend);
endmodule

// File: tb/div_bank_bench.sv
`timescale 1ns/100ps
module div_bank_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick_en = 1'b1, tick_half = 1'b0, phase = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] pulse;
  wire         tick = tick_en & (~tick_half | phase);

  int checks = 0, fails = 0;
  logic [31:0] sh_a = '0, sh_b = '0;
  logic [10:0] exp_st = '0;

  localparam int B_LSB [11] = '{20, 16, 8, 8, 4, 0, 24, 20, 16, 12, 4};
  localparam logic [10:0] B_IN_B = 11'b111_1100_0000;
  localparam int NV = 12;
  localparam int V_OUT  [NV] = '{4, 5, 1, 6, 7, 0, 9, 6, 2, 8, 10, 7};
  localparam int V_CODE [NV] = '{1, 11, 10, 9, 14, 7, 10, 8, 6, 3, 5, 4};
  localparam int V_DIV  [NV] = '{3, 48, 2, 2, 2, 18, 36, 24, 16, 6, 12, 8};
  localparam int V_ERR  [NV] = '{0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0};

  div_bank u_div_bank (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pulse_o(pulse)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) phase <= ~phase;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic set_code(input int o, input logic [3:0] c);
    if (B_IN_B[o]) begin sh_b[B_LSB[o] +: 4] = c; wr(2'd1, sh_b); end
    else begin sh_a[B_LSB[o] +: 4] = c; wr(2'd0, sh_a); end
  endtask

  task automatic kick(input string req);
    logic [31:0] d;
    wr(2'd1, sh_b | 32'h8000_0000);
    d = 32'h8000_0000;
    for (int i = 0; i < 400 && d[31]; i++) rd(2'd1, d);
    check(req, d[31], 0);
  endtask

  task automatic measure(input int o, output int n);
    int w;
    w = 0;
    n = 0;
    @(negedge clk);
    while (!pulse[o] && w < 400) begin @(negedge clk); w++; end
    if (w >= 400) return;
    do begin @(negedge clk); n++; end while (!pulse[o] && n < 400);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd(2'd0, d); check("R7 reset A", d, 0);
    rd(2'd1, d); check("R7 reset B", d, 0);
    rd(2'd2, d); check("R7 reset status", d, 0);
    rd(2'd3, d); check("R7 reset run", d, 32'h00F);
    measure(0, n); check("R1 R2 R7 out0 default /2", n, 2);
    measure(3, n); check("R7 out3 default /2", n, 2);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (|pulse[10:4]) cnt++; end
    check("R7 stopped outputs silent", cnt, 0);
    wr(2'd3, 32'h7FF);
    kick("R4 enable kick");
    measure(10, n); check("R7 out10 enabled /2", n, 2);

    // table walk: R1 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      set_code(V_OUT[v], 4'(V_CODE[v]));
      kick("R4 kick clears");
      measure(V_OUT[v], n); check("R1 R5 vector period", n, V_DIV[v]);
      if (V_ERR[v] != 0) exp_st[V_OUT[v]] = 1'b1;
      rd(2'd2, d); check("R5 status", d, {21'd0, exp_st});
    end
    measure(3, n); check("R6 out3 shares field of out2", n, 16);
    rd(2'd0, d); check("R6 A readback", d, sh_a);
    rd(2'd1, d); check("R6 B readback", d, sh_b);

    // R3 shadow only until kick
    set_code(4, 4'd0);
    rd(2'd0, d); check("R3 shadow readback", d, sh_a);
    measure(4, n); check("R3 no effect before kick", n, 3);
    kick("R4 kick clears");
    measure(4, n); check("R3 R4 applied after kick", n, 2);

    // R5 write-1 clear
    wr(2'd2, 32'h40);
    exp_st[6] = 1'b0;
    rd(2'd2, d); check("R5 w1c status", d, {21'd0, exp_st});

    // R2 half-rate tick
    tick_half = 1'b1;
    measure(0, n); check("R2 half-rate tick out0 /18", n, 36);
    tick_half = 1'b0;

    // R8 tick low holds kick
    @(negedge clk); tick_en = 1'b0;
    set_code(4, 4'd2);
    wr(2'd1, sh_b | 32'h8000_0000);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (|pulse) cnt++; end
    check("R8 no pulses without tick", cnt, 0);
    rd(2'd1, d); check("R8 kick stays pending", d[31], 1);
    tick_en = 1'b1;
    d = 32'h8000_0000;
    for (int i = 0; i < 400 && d[31]; i++) rd(2'd1, d);
    check("R4 R8 kick served after tick", d[31], 0);
    measure(4, n); check("R8 new ratio /4", n, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule